// File: doc/BRIEF.md
# Trap Priority and Masking Arbiter

This block decides, at each instruction boundary, which pending event the core takes. Five sources compete. A non-maskable interrupt, a maskable external interrupt that carries a vector, a software interrupt, a timer interrupt and a synchronous exception with a cause code. The winner is reported as a one-cycle take strobe, a cause, and a code. The code is the vector for an external interrupt and the cause code for an exception.

The block holds the masking state. This is a global interrupt-enable flag with a one-level saved copy, per-source enables for the three maskable interrupts, a class threshold for external interrupts, and a hidden bit that blocks further non-maskable interrupts. Taking a trap clears the global enable. A return-from-trap restores the global enable and always releases the non-maskable block. An exception that loses arbitration is not kept. It comes back when the faulting instruction executes again.

Top module: `trap_arbiter`

## Requirements
- R1: `take_o` is high only in a cycle where `boundary_i` is high and `trap_ret_i` is low. It is combinational from the current inputs and state, so it lasts one cycle for each boundary.
- R2: Among eligible sources the winner follows a fixed order. The non-maskable interrupt comes first, then external, then software, then timer, then the synchronous exception.
- R3: While `gie_o` is 0, the external, software and timer interrupts are never taken. The non-maskable interrupt and synchronous exceptions are still taken.
- R4: Each maskable interrupt is taken only while its enable bit in `en_o` is 1. Bit 0 is external, bit 1 is software and bit 2 is timer.
- R5: An external interrupt is taken only when the upper 4 bits of `ext_vec_i` are strictly greater than `thr_o`. Taking a trap leaves `thr_o` unchanged.
- R6: Taking a non-maskable interrupt sets `nmi_blk_o`. While `nmi_blk_o` is 1 a non-maskable request is not taken, but other sources still are.
- R7: A return-from-trap clears `nmi_blk_o`, including a return from an exception taken inside the non-maskable handler. It also sets `gie_o` to the value it had when the last trap was taken.
- R8: Taking any trap clears `gie_o` in the next cycle.
- R9: A synchronous exception that loses arbitration is not stored. With no request at the next boundary, no trap is taken.
- R10: `cause_o` encodes none=0, NMI=1, external=2, software=3, timer=4, exception=5. `code_o` carries `ext_vec_i` for an external interrupt, the zero-extended `exc_code_i` for an exception, and 0 otherwise. `eoi_o` is high exactly when an external interrupt is taken.
- R11: After reset, `gie_o`, `en_o`, `thr_o` and `nmi_blk_o` are all 0, and the saved enable is 0.
- R12: `cfg_we_i` loads `gie_o`, `en_o` and `thr_o` at the clock edge. If a trap is taken in the same cycle, the global enable is cleared rather than loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary: arbitration allowed |
| trap_ret_i | input | 1 | Return-from-trap retires this cycle |
| cfg_we_i | input | 1 | Load mask configuration |
| cfg_gie_i | input | 1 | Global enable value to load |
| cfg_en_i | input | 3 | Per-source enables to load (ext, sw, timer) |
| cfg_thr_i | input | CLS_W (4) | Class threshold to load |
| nmi_i | input | 1 | Non-maskable interrupt request |
| ext_req_i | input | 1 | External interrupt request |
| ext_vec_i | input | VEC_W (8) | External interrupt vector |
| sw_req_i | input | 1 | Software interrupt request |
| tmr_req_i | input | 1 | Timer interrupt request |
| exc_req_i | input | 1 | Synchronous exception flag |
| exc_code_i | input | EXC_W (5) | Exception cause code |
| take_o | output | 1 | Take trap this cycle |
| cause_o | output | 3 | Selected cause |
| code_o | output | VEC_W (8) | Vector or cause code |
| eoi_o | output | 1 | Taken event needs an end-of-interrupt acknowledge |
| gie_o | output | 1 | Global interrupt enable |
| en_o | output | 3 | Per-source enables |
| thr_o | output | CLS_W (4) | Class threshold |
| nmi_blk_o | output | 1 | Non-maskable interrupts blocked |

## Verification
The bench builds the block with its default parameters: an 8-bit vector, a 4-bit class and a 5-bit cause code. With a 4-bit class, the boundary vectors 0x3F and 0x40 straddle a threshold of 3, and a threshold of 15 blocks every vector. The defaults also allow nested traps inside the non-maskable handler and the single-level restore of the global enable to be checked across a full take-and-return sequence.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_NMI  = 3'd1,
    CAUSE_EXT  = 3'd2,
    CAUSE_SW   = 3'd3,
    CAUSE_TMR  = 3'd4,
    CAUSE_EXC  = 3'd5
  } cause_e;

  // source index == priority rank (0 highest)
  localparam int unsigned NSRC    = 5;
  localparam int unsigned SRC_NMI = 0;
  localparam int unsigned SRC_EXT = 1;
  localparam int unsigned SRC_SW  = 2;
  localparam int unsigned SRC_TMR = 3;
  localparam int unsigned SRC_EXC = 4;

  // maskable enable bit positions
  localparam int unsigned NMSK   = 3;
  localparam int unsigned EN_EXT = 0;
  localparam int unsigned EN_SW  = 1;
  localparam int unsigned EN_TMR = 2;
endpackage

// File: rtl/trap_qualify.sv
module trap_qualify
  import trap_pkg::*;
#(
  parameter int unsigned CLS_W = 4
) (
  input  logic             gie_i,
  input  logic [NMSK-1:0]  en_i,
  input  logic [CLS_W-1:0] thr_i,
  input  logic             nmi_blk_i,
  input  logic             nmi_i,
  input  logic             ext_req_i,
  input  logic [CLS_W-1:0] ext_cls_i,
  input  logic             sw_req_i,
  input  logic             tmr_req_i,
  input  logic             exc_req_i,
  output logic [NSRC-1:0]  elig_o
);
  always_comb begin
    elig_o          = '0;
    elig_o[SRC_NMI] = nmi_i & ~nmi_blk_i;
    elig_o[SRC_EXT] = gie_i & en_i[EN_EXT] & ext_req_i & (ext_cls_i > thr_i);
    elig_o[SRC_SW]  = gie_i & en_i[EN_SW] & sw_req_i;
    elig_o[SRC_TMR] = gie_i & en_i[EN_TMR] & tmr_req_i;
    elig_o[SRC_EXC] = exc_req_i;
  end
endmodule

// File: rtl/trap_pick.sv
module trap_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] higher;  // some lower-index request is active

  assign higher[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign higher[i] = higher[i-1] | req_i[i-1];
  end
  assign gnt_o = req_i & ~higher;

  always_comb begin
    a_r2_single_grant: assert ($onehot0(gnt_o));
    a_r2_grant_if_any: assert ((|req_i) == (|gnt_o));
  end
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int unsigned CLS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             take_nmi_i,
  input  logic             ret_i,
  input  logic             cfg_we_i,
  input  logic             cfg_gie_i,
  input  logic [NMSK-1:0]  cfg_en_i,
  input  logic [CLS_W-1:0] cfg_thr_i,
  output logic             gie_o,
  output logic [NMSK-1:0]  en_o,
  output logic [CLS_W-1:0] thr_o,
  output logic             nmi_blk_o
);
  logic gie_q, gie_saved_q, nmi_blk_q;
  logic [NMSK-1:0]  en_q;
  logic [CLS_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q       <= 1'b0;
      gie_saved_q <= 1'b0;
    end else if (take_i) begin
      gie_saved_q <= gie_q;
      gie_q       <= 1'b0;
    end else if (ret_i) begin
      gie_q <= gie_saved_q;
    end else if (cfg_we_i) begin
      gie_q <= cfg_gie_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_q <= '0;
    end else if (cfg_we_i) begin
      en_q  <= cfg_en_i;
      thr_q <= cfg_thr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         nmi_blk_q <= 1'b0;
    else if (take_nmi_i) nmi_blk_q <= 1'b1;
    else if (ret_i)      nmi_blk_q <= 1'b0;
  end

  assign gie_o     = gie_q;
  assign en_o      = en_q;
  assign thr_o     = thr_q;
  assign nmi_blk_o = nmi_blk_q;

  a_r7_ret_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !take_i) |=> (gie_q == $past(gie_saved_q)));
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned CLS_W = 4,
  parameter int unsigned EXC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic             trap_ret_i,
  input  logic             cfg_we_i,
  input  logic             cfg_gie_i,
  input  logic [2:0]       cfg_en_i,
  input  logic [CLS_W-1:0] cfg_thr_i,
  input  logic             nmi_i,
  input  logic             ext_req_i,
  input  logic [VEC_W-1:0] ext_vec_i,
  input  logic             sw_req_i,
  input  logic             tmr_req_i,
  input  logic             exc_req_i,
  input  logic [EXC_W-1:0] exc_code_i,
  output logic             take_o,
  output logic [2:0]       cause_o,
  output logic [VEC_W-1:0] code_o,
  output logic             eoi_o,
  output logic             gie_o,
  output logic [2:0]       en_o,
  output logic [CLS_W-1:0] thr_o,
  output logic             nmi_blk_o
);
  localparam int unsigned CLS_LSB = VEC_W - CLS_W;

  logic [NSRC-1:0] elig, gnt;
  logic            arb_en, take;
  cause_e          cause;

  trap_qualify #(.CLS_W(CLS_W)) i_qualify (
    .gie_i     (gie_o),
    .en_i      (en_o),
    .thr_i     (thr_o),
    .nmi_blk_i (nmi_blk_o),
    .nmi_i     (nmi_i),
    .ext_req_i (ext_req_i),
    .ext_cls_i (ext_vec_i[VEC_W-1:CLS_LSB]),
    .sw_req_i  (sw_req_i),
    .tmr_req_i (tmr_req_i),
    .exc_req_i (exc_req_i),
    .elig_o    (elig)
  );

  trap_pick #(.N(NSRC)) i_pick (
    .req_i (elig),
    .gnt_o (gnt)
  );

  // a retiring return owns this boundary; events are seen at the next one
  assign arb_en = boundary_i & ~trap_ret_i;
  assign take   = arb_en & (|elig);

  always_comb begin
    cause  = CAUSE_NONE;
    code_o = '0;
    if (take) begin
      unique case (1'b1)
        gnt[SRC_NMI]: cause = CAUSE_NMI;
        gnt[SRC_EXT]: begin cause = CAUSE_EXT; code_o = ext_vec_i; end
        gnt[SRC_SW]:  cause = CAUSE_SW;
        gnt[SRC_TMR]: cause = CAUSE_TMR;
        gnt[SRC_EXC]: begin cause = CAUSE_EXC; code_o = VEC_W'(exc_code_i); end
        default:      cause = CAUSE_NONE;
      endcase
    end
  end

  assign take_o  = take;
  assign cause_o = cause;
  assign eoi_o   = take & gnt[SRC_EXT];

  trap_state #(.CLS_W(CLS_W)) i_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .take_nmi_i (take & gnt[SRC_NMI]),
    .ret_i      (trap_ret_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_gie_i  (cfg_gie_i),
    .cfg_en_i   (cfg_en_i),
    .cfg_thr_i  (cfg_thr_i),
    .gie_o      (gie_o),
    .en_o       (en_o),
    .thr_o      (thr_o),
    .nmi_blk_o  (nmi_blk_o)
  );

  a_r1_take_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (boundary_i && !trap_ret_i));
  a_r3_exc_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !trap_ret_i && exc_req_i) |-> take_o);
  a_r3_masked_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !gie_o) |-> (cause_o == CAUSE_NMI || cause_o == CAUSE_EXC));
  a_r5_cls_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == CAUSE_EXT) |-> (ext_vec_i[VEC_W-1:CLS_LSB] > thr_o));
  a_r5_thr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !cfg_we_i) |=> $stable(thr_o));
  a_r6_nmi_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == CAUSE_NMI) |=> nmi_blk_o);
  a_r6_no_nmi_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_blk_o |-> !(take_o && cause_o == CAUSE_NMI));
  a_r7_ret_unblocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_ret_i |=> !nmi_blk_o);
  a_r8_gie_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !gie_o);
  a_r10_eoi_ext_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o == (take_o && cause_o == CAUSE_EXT));
endmodule

// File: tb/test_trap_arbiter.sv
module test_trap_arbiter;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned NV     = 13;

  typedef struct packed {
    logic       gie;
    logic [2:0] en;
    logic [3:0] thr;
    logic       nmi;
    logic       ext;
    logic [7:0] vec;
    logic       sw;
    logic       tmr;
    logic       exc;
    logic [4:0] ecode;
    logic       take;
    logic [2:0] cause;
    logic [7:0] code;
  } vec_t;

  // cause: 0 none, 1 nmi, 2 ext, 3 sw, 4 tmr, 5 exc
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'b111, 4'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 5'd2,  1'b1, 3'd5, 8'h02},
    '{1'b1, 3'b111, 4'd2, 1'b0, 1'b1, 8'h35, 1'b1, 1'b1, 1'b1, 5'd3,  1'b1, 3'd2, 8'h35},
    '{1'b1, 3'b111, 4'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 5'd3,  1'b1, 3'd3, 8'h00},
    '{1'b1, 3'b111, 4'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'd3,  1'b1, 3'd4, 8'h00},
    '{1'b1, 3'b111, 4'd0, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b1, 1'b1, 5'd3,  1'b1, 3'd1, 8'h00},
    '{1'b0, 3'b111, 4'd0, 1'b0, 1'b1, 8'hF0, 1'b1, 1'b1, 1'b0, 5'd0,  1'b0, 3'd0, 8'h00},
    '{1'b0, 3'b111, 4'd0, 1'b0, 1'b1, 8'hF0, 1'b1, 1'b1, 1'b1, 5'd7,  1'b1, 3'd5, 8'h07},
    '{1'b0, 3'b111, 4'd0, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b1, 1'b1, 5'd7,  1'b1, 3'd1, 8'h00},
    '{1'b1, 3'b111, 4'd3, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0, 1'b0, 5'd0,  1'b0, 3'd0, 8'h00},
    '{1'b1, 3'b111, 4'd3, 1'b0, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 5'd0,  1'b1, 3'd2, 8'h40},
    '{1'b1, 3'b110, 4'd0, 1'b0, 1'b1, 8'hF0, 1'b1, 1'b0, 1'b0, 5'd0,  1'b1, 3'd3, 8'h00},
    '{1'b1, 3'b101, 4'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 5'd0,  1'b1, 3'd4, 8'h00},
    '{1'b1, 3'b111, 4'd15,1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 5'd31, 1'b1, 3'd5, 8'h1F}
  };

  logic       clk, rst_n;
  logic       boundary, trap_ret, cfg_we, cfg_gie;
  logic [2:0] cfg_en;
  logic [3:0] cfg_thr;
  logic       nmi, ext_req, sw_req, tmr_req, exc_req;
  logic [7:0] ext_vec;
  logic [4:0] exc_code;
  logic       take, eoi, gie, nmi_blk;
  logic [2:0] cause, en;
  logic [7:0] code;
  logic [3:0] thr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  trap_arbiter i_trap_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .trap_ret_i(trap_ret),
    .cfg_we_i(cfg_we), .cfg_gie_i(cfg_gie), .cfg_en_i(cfg_en), .cfg_thr_i(cfg_thr),
    .nmi_i(nmi), .ext_req_i(ext_req), .ext_vec_i(ext_vec), .sw_req_i(sw_req),
    .tmr_req_i(tmr_req), .exc_req_i(exc_req), .exc_code_i(exc_code),
    .take_o(take), .cause_o(cause), .code_o(code), .eoi_o(eoi),
    .gie_o(gie), .en_o(en), .thr_o(thr), .nmi_blk_o(nmi_blk)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    boundary = 0; trap_ret = 0; cfg_we = 0; cfg_gie = 0; cfg_en = '0; cfg_thr = '0;
    nmi = 0; ext_req = 0; ext_vec = '0; sw_req = 0; tmr_req = 0; exc_req = 0; exc_code = '0;
  endtask

  // caller is just after a negedge; returns after next negedge
  task automatic cfg(input logic g, input logic [2:0] e, input logic [3:0] t);
    cfg_we = 1; cfg_gie = g; cfg_en = e; cfg_thr = t;
    @(negedge clk); idle();
  endtask

  task automatic ret();
    trap_ret = 1;
    @(negedge clk); idle();
  endtask

  task automatic events(input logic n, input logic x, input logic [7:0] v,
                        input logic s, input logic tm, input logic ex, input logic [4:0] ec);
    boundary = 1; nmi = n; ext_req = x; ext_vec = v; sw_req = s; tmr_req = tm;
    exc_req = ex; exc_code = ec;
    #1;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 gie", int'(gie), 0);
    check("R11 en", int'(en), 0);
    check("R11 thr", int'(thr), 0);
    check("R11 nmi_blk", int'(nmi_blk), 0);
    rst_n = 1;
    @(negedge clk);
    events(0, 1, 8'hF0, 1, 1, 0, 0);
    check("R11 no maskable after reset", int'(take), 0);
    step();

    // table walk: R2 R3 R4 R5 R10, plus R8/R7 on each take
    for (int i = 0; i < NV; i++) begin
      cfg(TBL[i].gie, TBL[i].en, TBL[i].thr);
      events(TBL[i].nmi, TBL[i].ext, TBL[i].vec, TBL[i].sw, TBL[i].tmr, TBL[i].exc, TBL[i].ecode);
      check($sformatf("R2 take v%0d", i), int'(take), int'(TBL[i].take));
      check($sformatf("R10 cause v%0d", i), int'(cause), int'(TBL[i].cause));
      check($sformatf("R10 code v%0d", i), int'(code), int'(TBL[i].code));
      check($sformatf("R10 eoi v%0d", i), int'(eoi), int'(TBL[i].take && TBL[i].cause == 3'd2));
      step();
      if (TBL[i].take) begin
        check($sformatf("R8 gie cleared v%0d", i), int'(gie), 0);
        check($sformatf("R5 thr kept v%0d", i), int'(thr), int'(TBL[i].thr));
        ret();
        check($sformatf("R7 gie restored v%0d", i), int'(gie), int'(TBL[i].gie));
        check($sformatf("R7 nmi unblocked v%0d", i), int'(nmi_blk), 0);
      end
    end

    // R1: no boundary -> no take; return cycle suppresses take
    cfg(1, 3'b111, 0);
    boundary = 0; exc_req = 1; nmi = 1; #1;
    check("R1 no boundary", int'(take), 0);
    step();
    trap_ret = 1; boundary = 1; exc_req = 1; #1;
    check("R1 suppressed in return cycle", int'(take), 0);
    step();

    // R6/R7: NMI blocking, nested exception, return clears block
    cfg(1, 3'b111, 0);
    events(1, 0, 0, 0, 0, 0, 0);
    check("R6 nmi taken", int'(cause), 1);
    step();
    check("R6 blocked set", int'(nmi_blk), 1);
    events(1, 0, 0, 0, 0, 0, 0);
    check("R6 second nmi held", int'(take), 0);
    step();
    events(1, 0, 0, 0, 0, 1, 5'd4);
    check("R6 exc taken inside nmi", int'(cause), 5);
    step();
    check("R6 still blocked", int'(nmi_blk), 1);
    ret();
    check("R7 nested return unblocks", int'(nmi_blk), 0);
    events(1, 0, 0, 0, 0, 0, 0);
    check("R7 nmi taken again", int'(cause), 1);
    step();
    ret();

    // R9: losing exception is not stored
    cfg(1, 3'b111, 0);
    events(0, 0, 0, 1, 0, 1, 5'd6);
    check("R9 sw beats exc", int'(cause), 3);
    step();
    events(0, 0, 0, 0, 0, 0, 0);
    check("R9 no replay", int'(take), 0);
    step();
    ret();
    events(0, 0, 0, 0, 0, 1, 5'd6);
    check("R9 exc on re-execute", int'(code), 6);
    step();
    ret();

    // R12: cfg write loads; take in same cycle wins for gie
    cfg(1, 3'b011, 4'd9);
    check("R12 gie loaded", int'(gie), 1);
    check("R12 en loaded", int'(en), 3);
    check("R12 thr loaded", int'(thr), 9);
    cfg_we = 1; cfg_gie = 1; cfg_en = 3'b111; cfg_thr = 4'd2;
    events(0, 0, 0, 0, 0, 1, 5'd1);
    step();
    check("R12 take overrides gie", int'(gie), 0);
    check("R12 thr still loaded", int'(thr), 2);
    ret();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule